// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table from memory, one word at a time, over a small request/response port. Those reads are physical accesses. They are never translated or cached themselves. A walk starts with a one-cycle request that carries three things: the virtual address, the table base value and a bit that enables tiny pages. After the walk, the block presents the physical address and a 2-bit cacheable/bufferable attribute. It signals either a one-cycle completion pulse or a one-cycle fault pulse.

A first-level entry can be one of four kinds: a fault, a 1 MB section, a coarse second-level table or a fine second-level table. A section finishes the walk after one read. Either table kind leads to a second read. That read returns a large (64 KB), small (4 KB) or tiny (1 KB) page entry, or a fault. Each kind has its own index arithmetic. The block accepts a request only while idle and raises busy for the whole walk.

Top module: `xlat_walker`

## Requirements
- R1: The first read goes to base bits [31:14], followed by virtual address bits [31:20], followed by two zero bits.
- R2: A first-level entry with bits [1:0] = 0 ends the walk with a fault after exactly one read.
- R3: A first-level entry with bits [1:0] = 3 while tiny pages are disabled ends the walk with a fault and makes no second read.
- R4: A first-level entry with bits [1:0] = 2 (section) completes after one read. The physical address is entry bits [31:20] joined with virtual address bits [19:0], and the attribute is entry bits [3:2].
- R5: A first-level entry with bits [1:0] = 1 (coarse) causes a second read at entry bits [31:10], followed by virtual address bits [19:12], followed by two zero bits.
- R6: A first-level entry with bits [1:0] = 3 while tiny pages are enabled (fine) causes a second read at entry bits [31:12], followed by virtual address bits [19:10], followed by two zero bits.
- R7: Bits [1:0] of the second-level entry decide the result.
  - Code 1 (large page): physical address is entry [31:16] with virtual address [15:0].
  - Code 2 (small page): physical address is entry [31:12] with virtual address [11:0].
  - Code 3 (tiny page): physical address is entry [31:10] with virtual address [9:0].
  - Code 0: the walk ends with a fault.
  - For every valid page, the attribute is second-level entry bits [3:2].
- R8: An error response to either read ends the walk with a fault.
- R9: Completion and fault are single-cycle pulses that never occur together. Accepting a request clears the physical address and the attribute to zero. A successful walk loads the result, a faulting walk leaves it at zero, and the result holds until the next accepted request.
- R10: A request is taken only while idle. Busy is high from the cycle after acceptance until the walk ends, and a request raised while busy is ignored.
- R11: A memory read request stays asserted with a stable, word-aligned address until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (one cycle, taken only when idle) |
| req_va | input | 32 | Virtual address to translate |
| req_tbase | input | 32 | Translation table base value |
| tiny_en | input | 1 | Enables tiny pages (fine first-level tables) |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Physical word read request |
| mem_addr | output | 32 | Read address, word aligned |
| mem_gnt | input | 1 | Read request accepted this cycle |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (descriptor) |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle pulse: translation complete |
| fault | output | 1 | One-cycle pulse: translation fault |
| pa | output | 32 | Physical address result |
| attr | output | 2 | Cacheable/bufferable result |

## Verification
The assertions check the following on every cycle:
- Pulse shape and exclusivity of completion and fault.
- Release of busy after a pulse.
- Stability of a request that has not yet been granted.
- The immediate fault after an error response, a disabled tiny table or an empty second-level entry.
- The section result built from the response word.
- That the result holds while the block is idle.

Only the bench scenarios can show the following:
- The read addresses for both table kinds.
- The page arithmetic for all three page sizes.
- The number of reads per walk.
- That a request raised mid-walk is dropped.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;

  localparam int unsigned ADDR_W         = 32;
  localparam int unsigned ATTR_W         = 2;
  localparam int unsigned ATTR_LSB       = 2;
  localparam int unsigned TBASE_LSB      = 14;
  localparam int unsigned SECTION_SHIFT  = 20;
  localparam int unsigned LARGE_SHIFT    = 16;
  localparam int unsigned SMALL_SHIFT    = 12;
  localparam int unsigned TINY_SHIFT     = 10;
  localparam int unsigned COARSE_PTR_LSB = 10;
  localparam int unsigned FINE_PTR_LSB   = 12;
  localparam int unsigned NUM_PAGE_KINDS = 3;
  localparam int unsigned WORD_SHIFT     = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ATTR_W-1:0] attr_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH1 = 3'd1,
    ST_WAIT1  = 3'd2,
    ST_FETCH2 = 3'd3,
    ST_WAIT2  = 3'd4,
    ST_DONE   = 3'd5,
    ST_FAULT  = 3'd6
  } walk_st_e;

  typedef enum logic [1:0] {
    L1_NONE    = 2'd0,
    L1_COARSE  = 2'd1,
    L1_SECTION = 2'd2,
    L1_FINE    = 2'd3
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_NONE  = 2'd0,
    L2_LARGE = 2'd1,
    L2_SMALL = 2'd2,
    L2_TINY  = 2'd3
  } l2_kind_e;

  // Mask with the low 'sh' bits set.
  function automatic addr_t f_low_mask(int unsigned sh);
    addr_t m;
    for (int unsigned i = 0; i < ADDR_W; i++) m[i] = (i < sh);
    return m;
  endfunction

  // Upper bits from 'hi', low 'sh' bits from 'lo'.
  function automatic addr_t f_splice(addr_t hi, addr_t lo, int unsigned sh);
    return (hi & ~f_low_mask(sh)) | (lo & f_low_mask(sh));
  endfunction

  // First-level entry word address.
  function automatic addr_t f_l1_addr(addr_t tbase, addr_t va);
    return (tbase & ~f_low_mask(TBASE_LSB)) | ((va >> SECTION_SHIFT) << WORD_SHIFT);
  endfunction

  // Second-level entry word address: table pointer plus scaled index.
  function automatic addr_t f_l2_addr(addr_t desc, addr_t va,
                                      int unsigned ptr_lsb, int unsigned pg_shift);
    addr_t idx;
    idx = (va >> pg_shift) & f_low_mask(ptr_lsb - WORD_SHIFT);
    return (desc & ~f_low_mask(ptr_lsb)) | (idx << WORD_SHIFT);
  endfunction

  function automatic attr_t f_attr(addr_t desc);
    return desc[ATTR_LSB +: ATTR_W];
  endfunction

endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
  import xlat_walker_pkg::*;
(
  input  addr_t desc,
  input  addr_t va,
  input  logic  tiny_en,
  output logic  is_fault,
  output logic  is_section,
  output addr_t l2_ptr,
  output addr_t sec_pa,
  output attr_t sec_attr
);

  l1_kind_e kind;
  addr_t    coarse_ptr;
  addr_t    fine_ptr;

  assign kind       = l1_kind_e'(desc[1:0]);
  assign coarse_ptr = f_l2_addr(desc, va, COARSE_PTR_LSB, SMALL_SHIFT);
  assign fine_ptr   = f_l2_addr(desc, va, FINE_PTR_LSB, TINY_SHIFT);
  assign sec_pa     = f_splice(desc, va, SECTION_SHIFT);
  assign sec_attr   = f_attr(desc);

  always_comb begin
    is_fault   = 1'b0;
    is_section = 1'b0;
    l2_ptr     = coarse_ptr;
    unique case (kind)
      L1_NONE:    is_fault   = 1'b1;
      L1_SECTION: is_section = 1'b1;
      L1_COARSE:  l2_ptr     = coarse_ptr;
      L1_FINE: begin
        l2_ptr   = fine_ptr;
        is_fault = !tiny_en;
      end
      default:    is_fault   = 1'b1;
    endcase
  end

endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
  import xlat_walker_pkg::*;
(
  input  addr_t desc,
  input  addr_t va,
  output logic  is_fault,
  output addr_t page_pa,
  output attr_t page_attr
);

  localparam int unsigned PAGE_SHIFT [NUM_PAGE_KINDS] =
    '{LARGE_SHIFT, SMALL_SHIFT, TINY_SHIFT};

  l2_kind_e kind;
  addr_t    cand [NUM_PAGE_KINDS];

  assign kind      = l2_kind_e'(desc[1:0]);
  assign page_attr = f_attr(desc);

  for (genvar k = 0; k < NUM_PAGE_KINDS; k++) begin : g_page
    assign cand[k] = f_splice(desc, va, PAGE_SHIFT[k]);
  end

  always_comb begin
    is_fault = 1'b0;
    page_pa  = '0;
    unique case (kind)
      L2_LARGE: page_pa  = cand[0];
      L2_SMALL: page_pa  = cand[1];
      L2_TINY:  page_pa  = cand[2];
      default:  is_fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/xlat_walk_ctrl.sv
module xlat_walk_ctrl
  import xlat_walker_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_gnt,
  input  logic     rsp_valid,
  input  logic     rsp_err,
  input  logic     l1_fault,
  input  logic     l1_section,
  input  logic     l2_fault,
  output walk_st_e state,
  output logic     ev_accept,
  output logic     ev_sec_load,
  output logic     ev_ptr_load,
  output logic     ev_page_load,
  output logic     ev_in_wait1,
  output logic     ev_in_wait2
);

  walk_st_e st_q, st_d;
  logic     l1_rsp, l2_rsp;

  assign state        = st_q;
  assign ev_in_wait1  = (st_q == ST_WAIT1);
  assign ev_in_wait2  = (st_q == ST_WAIT2);
  assign l1_rsp       = ev_in_wait1 && rsp_valid;
  assign l2_rsp       = ev_in_wait2 && rsp_valid;
  assign ev_accept    = (st_q == ST_IDLE) && req_valid;
  assign ev_sec_load  = l1_rsp && !rsp_err && !l1_fault && l1_section;
  assign ev_ptr_load  = l1_rsp && !rsp_err && !l1_fault && !l1_section;
  assign ev_page_load = l2_rsp && !rsp_err && !l2_fault;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid) st_d = ST_FETCH1;
      ST_FETCH1: if (mem_gnt)   st_d = ST_WAIT1;
      ST_WAIT1: begin
        if (rsp_valid) begin
          if (rsp_err || l1_fault) st_d = ST_FAULT;
          else if (l1_section)     st_d = ST_DONE;
          else                     st_d = ST_FETCH2;
        end
      end
      ST_FETCH2: if (mem_gnt)   st_d = ST_WAIT2;
      ST_WAIT2: begin
        if (rsp_valid) st_d = (rsp_err || l2_fault) ? ST_FAULT : ST_DONE;
      end
      ST_DONE:   st_d = ST_IDLE;
      ST_FAULT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_walker_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_va,
  input  logic [ADDR_W-1:0]   req_tbase,
  input  logic                tiny_en,
  output logic                busy,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_gnt,
  input  logic                mem_rsp_valid,
  input  logic [ADDR_W-1:0]   mem_rsp_data,
  input  logic                mem_rsp_err,
  output logic                done,
  output logic                fault,
  output logic [ADDR_W-1:0]   pa,
  output logic [ATTR_W-1:0]   attr
);

  walk_st_e st;
  logic     ev_accept, ev_sec_load, ev_ptr_load, ev_page_load;
  logic     ev_in_wait1, ev_in_wait2;
  logic     l1_fault, l1_section, l2_fault;
  addr_t    l1_ptr, sec_pa, l2_pa;
  attr_t    sec_attr, l2_attr;

  addr_t    va_q, tbase_q, ptr_q, pa_q;
  attr_t    attr_q;
  logic     tiny_q;

  xlat_walk_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_gnt      (mem_gnt),
    .rsp_valid    (mem_rsp_valid),
    .rsp_err      (mem_rsp_err),
    .l1_fault     (l1_fault),
    .l1_section   (l1_section),
    .l2_fault     (l2_fault),
    .state        (st),
    .ev_accept    (ev_accept),
    .ev_sec_load  (ev_sec_load),
    .ev_ptr_load  (ev_ptr_load),
    .ev_page_load (ev_page_load),
    .ev_in_wait1  (ev_in_wait1),
    .ev_in_wait2  (ev_in_wait2)
  );

  xlat_l1_decode u_l1 (
    .desc       (mem_rsp_data),
    .va         (va_q),
    .tiny_en    (tiny_q),
    .is_fault   (l1_fault),
    .is_section (l1_section),
    .l2_ptr     (l1_ptr),
    .sec_pa     (sec_pa),
    .sec_attr   (sec_attr)
  );

  xlat_l2_decode u_l2 (
    .desc      (mem_rsp_data),
    .va        (va_q),
    .is_fault  (l2_fault),
    .page_pa   (l2_pa),
    .page_attr (l2_attr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q    <= '0;
      tbase_q <= '0;
      tiny_q  <= 1'b0;
      ptr_q   <= '0;
      pa_q    <= '0;
      attr_q  <= '0;
    end else begin
      if (ev_accept) begin
        va_q    <= req_va;
        tbase_q <= req_tbase;
        tiny_q  <= tiny_en;
        pa_q    <= '0;
        attr_q  <= '0;
      end
      if (ev_ptr_load) ptr_q <= l1_ptr;
      if (ev_sec_load) begin
        pa_q   <= sec_pa;
        attr_q <= sec_attr;
      end
      if (ev_page_load) begin
        pa_q   <= l2_pa;
        attr_q <= l2_attr;
      end
    end
  end

  assign busy     = (st != ST_IDLE);
  assign mem_req  = (st == ST_FETCH1) || (st == ST_FETCH2);
  assign mem_addr = (st == ST_FETCH2) ? ptr_q : f_l1_addr(tbase_q, va_q);
  assign done     = (st == ST_DONE);
  assign fault    = (st == ST_FAULT);
  assign pa       = pa_q;
  assign attr     = attr_q;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xlat_walker_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  req_valid,
  input logic  busy,
  input logic  done,
  input logic  fault,
  input logic  mem_req,
  input logic  mem_gnt,
  input addr_t mem_addr,
  input logic  mem_rsp_valid,
  input addr_t mem_rsp_data,
  input logic  mem_rsp_err,
  input addr_t pa,
  input attr_t attr,
  input logic  in_wait1,
  input logic  in_wait2,
  input logic  tiny_q,
  input addr_t va_q
);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> ($stable(pa) && $stable(attr)));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !busy);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r8_err_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_wait1 || in_wait2) && mem_rsp_valid && mem_rsp_err) |=> fault);

  a_r3_tiny_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait1 && mem_rsp_valid && !mem_rsp_err && mem_rsp_data[1:0] == 2'b11 && !tiny_q)
      |=> fault);

  a_r2_l1_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait1 && mem_rsp_valid && !mem_rsp_err && mem_rsp_data[1:0] == 2'b00) |=> fault);

  a_r7_l2_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait2 && mem_rsp_valid && !mem_rsp_err && mem_rsp_data[1:0] == 2'b00) |=> fault);

  a_r4_section: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait1 && mem_rsp_valid && !mem_rsp_err && mem_rsp_data[1:0] == 2'b10)
      |=> (done && pa == {$past(mem_rsp_data[31:20]), va_q[19:0]}
               && attr == $past(mem_rsp_data[3:2])));

endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .busy          (busy),
  .done          (done),
  .fault         (fault),
  .mem_req       (mem_req),
  .mem_gnt       (mem_gnt),
  .mem_addr      (mem_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .mem_rsp_err   (mem_rsp_err),
  .pa            (pa),
  .attr          (attr),
  .in_wait1      (ev_in_wait1),
  .in_wait2      (ev_in_wait2),
  .tiny_q        (tiny_q),
  .va_q          (va_q)
);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] tbase;
    logic [31:0] d1;
    logic [31:0] d2;
    logic        tiny;
    logic [1:0]  err_at;
    logic [2:0]  stall;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 32'h0004_3ABC, 32'hABC0_000E, 32'h0000_0000, 1'b0, 2'd0, 3'd0},
    '{32'h8765_4321, 32'h1000_0000, 32'h0012_3401, 32'h5555_6006, 1'b0, 2'd0, 3'd3},
    '{32'hFFFF_FFFF, 32'hFFFF_C000, 32'h0000_0C01, 32'hCAFE_0009, 1'b0, 2'd0, 3'd0},
    '{32'h0001_2345, 32'h0000_0000, 32'h4000_0001, 32'h7654_340F, 1'b0, 2'd0, 3'd1},
    '{32'hDEAD_BEEF, 32'h2000_0000, 32'h3000_1003, 32'h9ABC_DC07, 1'b1, 2'd0, 3'd0},
    '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_F003, 32'h1111_1002, 1'b1, 2'd0, 3'd2},
    '{32'hDEAD_BEEF, 32'h2000_0000, 32'h3000_1003, 32'h9ABC_DC07, 1'b0, 2'd0, 3'd0},
    '{32'h0BAD_F00D, 32'h0000_0000, 32'hFFFF_FFFC, 32'h0000_0000, 1'b1, 2'd0, 3'd0},
    '{32'h0040_1000, 32'h8000_0000, 32'h0000_0401, 32'hFFFF_FFF0, 1'b1, 2'd0, 3'd0},
    '{32'h00AB_CDEF, 32'h0000_0000, 32'h0010_0006, 32'h0000_0000, 1'b1, 2'd0, 3'd0},
    '{32'h8765_4321, 32'h1000_0000, 32'h0012_3401, 32'h5555_6006, 1'b0, 2'd1, 3'd0},
    '{32'hFFFF_FFFF, 32'hFFFF_C000, 32'h0000_0C01, 32'hCAFE_0009, 1'b0, 2'd2, 3'd1},
    '{32'h7FFF_1234, 32'h0000_0000, 32'h0000_2003, 32'h1234_5FF5, 1'b1, 2'd0, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_va, req_tbase;
  logic        tiny_en;
  logic        busy, mem_req, mem_gnt, mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_addr, mem_rsp_data, pa;
  logic        done, fault;
  logic [1:0]  attr;

  int checks = 0;
  int fails  = 0;

  // memory model state
  logic [31:0] m_d1, m_d2;
  logic [1:0]  m_err_at;
  int          stall_left = 0;
  int          nreads     = 0;
  bit          pending    = 1'b0;
  logic [31:0] rd_addr [4];

  always #2 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_va        (req_va),
    .req_tbase     (req_tbase),
    .tiny_en       (tiny_en),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_gnt       (mem_gnt),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .done          (done),
    .fault         (fault),
    .pa            (pa),
    .attr          (attr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Memory: grants after the requested stall, answers on the next cycle.
  initial begin
    mem_gnt = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
      if (pending) begin
        pending = 1'b0;
        nreads++;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = (nreads == 1) ? m_d1 : m_d2;
        mem_rsp_err   = (int'(m_err_at) == nreads);
      end else begin
        if (mem_req && stall_left > 0) begin
          mem_gnt = 1'b0;
          stall_left--;
        end else begin
          mem_gnt = 1'b1;
        end
        if (mem_req && mem_gnt) begin
          if (nreads < 4) rd_addr[nreads] = mem_addr;
          pending = 1'b1;
        end
      end
    end
  end

  // Independent reference written with integer arithmetic.
  function automatic void model(input vec_t v, output bit f, output logic [31:0] p,
                                output logic [1:0] c, output int nr,
                                output logic [31:0] a1, output logic [31:0] a2,
                                output string tag);
    logic [31:0] t, u, sz;
    a1 = (v.tbase / 32'h4000) * 32'h4000 + (v.va / 32'h10_0000) * 4;
    a2 = '0; p = '0; c = '0; f = 1'b1; nr = 1;
    t = v.d1 % 4;
    if (v.err_at == 2'd1)           tag = "R8";
    else if (t == 0)                tag = "R2";
    else if (t == 3 && !v.tiny)     tag = "R3";
    else if (t == 2) begin
      tag = "R4"; f = 1'b0;
      p = (v.d1 / 32'h10_0000) * 32'h10_0000 + v.va % 32'h10_0000;
      c = 2'((v.d1 / 4) % 4);
    end else begin
      nr = 2;
      if (t == 1) a2 = (v.d1 / 1024) * 1024 + ((v.va / 4096) % 256) * 4;
      else        a2 = (v.d1 / 4096) * 4096 + ((v.va / 1024) % 1024) * 4;
      u = v.d2 % 4;
      if (v.err_at == 2'd2)  tag = "R8";
      else if (u == 0)       tag = "R7";
      else begin
        tag = "R7"; f = 1'b0;
        sz = (u == 1) ? 32'h1_0000 : (u == 2) ? 32'h1000 : 32'h400;
        p = (v.d2 / sz) * sz + v.va % sz;
        c = 2'((v.d2 / 4) % 4);
      end
    end
  endfunction

  task automatic start_walk(input vec_t v);
    m_d1 = v.d1; m_d2 = v.d2; m_err_at = v.err_at;
    stall_left = int'(v.stall); nreads = 0;
    for (int k = 0; k < 4; k++) rd_addr[k] = 32'hDEAD_0001;
    req_va = v.va; req_tbase = v.tbase; tiny_en = v.tiny; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R10", {31'd0, busy}, 32'd1);
  endtask

  task automatic finish_walk(output bit gd, output bit gf);
    for (int k = 0; k < 200; k++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    gd = done; gf = fault;
  endtask

  task automatic run_vec(input vec_t v);
    bit f, gd, gf; logic [31:0] p, a1, a2; logic [1:0] c; int nr; string tag;
    model(v, f, p, c, nr, a1, a2, tag);
    start_walk(v);
    finish_walk(gd, gf);
    chk(gd == !f && gf == f, tag, {30'd0, gd, gf}, {30'd0, !f, f});
    chk(pa === p, f ? "R9" : tag, pa, p);
    chk(attr === c, f ? "R9" : tag, {30'd0, attr}, {30'd0, c});
    chk(rd_addr[0] === a1, "R1", rd_addr[0], a1);
    if (nr == 2) chk(rd_addr[1] === a2, (v.d1 % 4 == 1) ? "R5" : "R6", rd_addr[1], a2);
    @(negedge clk);
    chk(nreads == nr, tag, nreads, nr);
    chk(!done && !fault && !busy, "R9", {29'd0, done, fault, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit gd, gf, f; logic [31:0] p, a1, a2, held; logic [1:0] c; int nr; string tag;
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_tbase = '0; tiny_en = 1'b0;
    m_d1 = '0; m_d2 = '0; m_err_at = '0;
    repeat (3) @(negedge clk);
    // reset state (R9, R10)
    chk(!busy && !done && !fault && !mem_req, "R10", {28'd0, busy, done, fault, mem_req}, 32'd0);
    chk(pa === 32'd0 && attr === 2'd0, "R9", pa, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: result held while idle after a successful walk
    run_vec(VECS[0]);
    held = pa;
    repeat (5) @(negedge clk);
    chk(pa === held, "R9", pa, held);

    // R11: request held with a stable address while not granted
    begin
      vec_t v; v = VECS[1]; v.stall = 3'd3;
      model(v, f, p, c, nr, a1, a2, tag);
      start_walk(v);
      for (int k = 0; k < 3; k++) begin
        chk(mem_req === 1'b1 && mem_addr === a1, "R11", mem_addr, a1);
        @(negedge clk);
      end
      finish_walk(gd, gf);
      chk(gd && pa === p, "R11", pa, p);
      @(negedge clk);
    end

    // R10: a request raised mid-walk is ignored
    begin
      vec_t v; v = VECS[1]; v.stall = 3'd2;
      model(v, f, p, c, nr, a1, a2, tag);
      start_walk(v);
      req_va = 32'h0000_0000; req_tbase = 32'hFFFF_C000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      finish_walk(gd, gf);
      chk(gd && pa === p, "R10", pa, p);
      chk(rd_addr[0] === a1, "R10", rd_addr[0], a1);
      repeat (4) @(negedge clk);
      chk(!busy && nreads == 2, "R10", nreads, 2);
    end

    summary();
    $finish;
  end

endmodule